// File: doc/BRIEF.md
# Reset, Brown-out and Watchdog Controller

This block produces the internal reset of a small microcontroller core and keeps the watchdog and sleep status that the core reads after a restart. Four things can put the core into reset: an asynchronous power-on reset, an active-low external master clear, a brown-out comparator output, and a watchdog time-out. The master clear input is synchronised and then passes through a debounce filter before it has any effect. When the core is asleep, a wake-on-pin-change event also restarts it. Every restart is stretched by a start-up timer. The timer counts ticks of a separate slow oscillator and is much shorter when the oscillator fuses select the RC mode.

The watchdog counts the same slow ticks. Two things can enable it: a configuration fuse, or an active-low software enable bit that the core writes. The fuse value is captured when the core enters sleep and is held for as long as the sleep lasts. Brown-out detection is off after power-up. Software arms it by writing 0 to an active-low arm bit. While the comparator reports low supply and detection is armed, the core stays in reset. Two status flags, time-out (TO) and power-down (PD), record how the core last stopped. The core reads them to tell a watchdog restart from a master clear and a wake from a cold start.

Top module: `rst_guard`

## Requirements
- R1: While `por_n` is low, `core_rst`=1, `to_flag`=1, `pd_flag`=1 and `wdt_event`=0. Both option bits (`opt_swdt_n`, `opt_bo_n` copies) come up as 1, so the software watchdog is off and brown-out is disarmed. Only `por_n` resets these two bits.
- R2: `mclr_n` passes a two-flop synchroniser and then a filter. A new synchronised level takes effect only after FILT_LEN consecutive clock samples. A low pulse shorter than FILT_LEN cycles causes no reset. A pulse of FILT_LEN cycles does.
- R3: Once every reset cause is gone, `core_rst` stays 1 until a number of `slow_tick` pulses has been counted, then falls. That number is DRT_SHORT when `fuse_osc`==2'b11 (RC mode) and DRT_LONG for the other three codes. The same rule applies after every kind of reset.
- R4: When armed (`opt_bo_n`=0), `bod_low`=1 holds `core_rst` at 1 for as long as it lasts. When disarmed, `bod_low` has no effect.
- R5: The watchdog is enabled when the fuse is 1 or the software bit `opt_swdt_n` is 0. While the core is asleep, the fuse value used is the one captured at sleep entry. A disabled watchdog keeps its count at zero.
- R6: With the watchdog enabled, the WDT_LIMIT-th `slow_tick` since the last clear produces a one-cycle `wdt_event`, sets `core_rst` to 1 and clears `to_flag` to 0. `pd_flag` is left unchanged.
- R7: A `clrwdt` strobe clears the watchdog count and sets `to_flag`=1 and `pd_flag`=1.
- R8: A `sleep_cmd` strobe clears the watchdog count, sets `to_flag`=1 and `pd_flag`=0, and puts the block into sleep.
- R9: `wake_pin` restarts the core through the start-up timer only while asleep, and leaves TO and PD unchanged. While the core is awake it has no effect.
- R10: `clrwdt`, `sleep_cmd` and option writes (`opt_we`) are ignored while `core_rst` is 1.
- R11: Master clear and brown-out resets leave `to_flag` and `pd_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mclr_n | input | 1 | Raw external master clear, active low |
| bod_low | input | 1 | Brown-out comparator, 1 = supply below trip |
| slow_tick | input | 1 | One-cycle pulse per slow oscillator period |
| fuse_wdt | input | 1 | Watchdog enable fuse |
| fuse_osc | input | 2 | Oscillator mode fuses, 2'b11 = RC |
| opt_we | input | 1 | Write strobe for the two option bits |
| opt_swdt_n | input | 1 | Software watchdog enable, active low |
| opt_bo_n | input | 1 | Brown-out arm, active low |
| clrwdt | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep entry strobe |
| wake_pin | input | 1 | Pin-change wake event |
| core_rst | output | 1 | Core reset, active high |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| wdt_event | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The assertions check four things on every cycle. A time-out pulse always comes with reset and lasts one cycle. TO falls only with a time-out and PD falls only after a sleep strobe. An armed brown-out or filtered master clear forces reset on the next edge, and reset is released only on a slow tick. Several behaviours can only be shown by the bench's scenarios. These are the exact start-up tick counts for every oscillator code, the boundary between ignored and accepted master clear widths, the watchdog tick limit, and the fuse value held through sleep. The bench also shows that a clear strobe restarts the count, that a clear strobe during reset is ignored, and that wake events are ignored while the core is awake.

// File: rtl/rst_guard.sv
module rst_guard #(
  parameter int FILT_LEN  = 4,
  parameter int DRT_SHORT = 4,
  parameter int DRT_LONG  = 72,
  parameter int WDT_LIMIT = 32
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       mclr_n,
  input  logic       bod_low,
  input  logic       slow_tick,
  input  logic       fuse_wdt,
  input  logic [1:0] fuse_osc,
  input  logic       opt_we,
  input  logic       opt_swdt_n,
  input  logic       opt_bo_n,
  input  logic       clrwdt,
  input  logic       sleep_cmd,
  input  logic       wake_pin,
  output logic       core_rst,
  output logic       to_flag,
  output logic       pd_flag,
  output logic       wdt_event
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int DW = $clog2(DRT_LONG + DRT_SHORT + 1);
  localparam int WW = $clog2(WDT_LIMIT + 1);

  logic [1:0]    mclr_sync;
  logic          mclr_f;
  logic [FW-1:0] fcnt;
  logic          swdt_n, bo_n;
  logic          asleep, fuse_lat;
  logic [DW-1:0] dcnt;
  logic [WW-1:0] wcnt;

  wire           active   = !core_rst;
  wire           hold     = !mclr_f || (!bo_n && bod_low);
  wire           wdt_en   = (asleep ? fuse_lat : fuse_wdt) || !swdt_n;
  wire           do_sleep = sleep_cmd && active;
  wire           do_clr   = clrwdt && active && !sleep_cmd;
  wire           wdt_to   = active && wdt_en && slow_tick && !sleep_cmd && !clrwdt
                            && (wcnt == WW'(WDT_LIMIT - 1));
  wire           wake     = asleep && wake_pin;
  wire           trigger  = hold || wdt_to || wake;
  wire [DW-1:0]  drt_len  = (fuse_osc == 2'b11) ? DW'(DRT_SHORT) : DW'(DRT_LONG);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mclr_sync <= 2'b11;
      mclr_f    <= 1'b1;
      fcnt      <= '0;
    end else begin
      mclr_sync <= {mclr_sync[0], mclr_n};
      if (mclr_sync[1] == mclr_f)
        fcnt <= '0;
      else if (fcnt == FW'(FILT_LEN - 1)) begin
        mclr_f <= mclr_sync[1];
        fcnt   <= '0;
      end else
        fcnt <= fcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      swdt_n <= 1'b1;
      bo_n   <= 1'b1;
    end else if (opt_we && active) begin
      swdt_n <= opt_swdt_n;
      bo_n   <= opt_bo_n;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      core_rst <= 1'b1;
      dcnt     <= '0;
    end else if (trigger) begin
      core_rst <= 1'b1;
      dcnt     <= '0;
    end else if (core_rst && slow_tick) begin
      if (dcnt == drt_len - DW'(1)) begin
        core_rst <= 1'b0;
        dcnt     <= '0;
      end else
        dcnt <= dcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)
      wcnt <= '0;
    else if (core_rst || !wdt_en || do_sleep || do_clr || wdt_to)
      wcnt <= '0;
    else if (slow_tick)
      wcnt <= wcnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      asleep   <= 1'b0;
      fuse_lat <= 1'b0;
    end else if (trigger)
      asleep <= 1'b0;
    else if (do_sleep) begin
      asleep   <= 1'b1;
      fuse_lat <= fuse_wdt;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      to_flag   <= 1'b1;
      pd_flag   <= 1'b1;
      wdt_event <= 1'b0;
    end else begin
      wdt_event <= wdt_to;
      if (wdt_to)
        to_flag <= 1'b0;
      else if (do_sleep) begin
        to_flag <= 1'b1;
        pd_flag <= 1'b0;
      end else if (do_clr) begin
        to_flag <= 1'b1;
        pd_flag <= 1'b1;
      end
    end

  AST_EVENT_RESETS: assert property (@(posedge clk) disable iff (!por_n) wdt_event |-> core_rst); // R6
  AST_EVENT_PULSE:  assert property (@(posedge clk) disable iff (!por_n) wdt_event |=> !wdt_event); // R6
  AST_TO_FALL:      assert property (@(posedge clk) disable iff (!por_n) $fell(to_flag) |-> wdt_event); // R6
  AST_PD_FALL:      assert property (@(posedge clk) disable iff (!por_n) $fell(pd_flag) |-> $past(sleep_cmd)); // R8
  AST_HOLD_RESET:   assert property (@(posedge clk) disable iff (!por_n) hold |=> core_rst); // R4
  AST_DRT_ON_TICK:  assert property (@(posedge clk) disable iff (!por_n) $fell(core_rst) |-> $past(slow_tick)); // R3
endmodule

// File: tb/sim_rst_guard.sv
module sim_rst_guard;
  localparam int FL = 4, DS = 4, DL = 72, WL = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n, mclr_n, bod_low, slow_tick, fuse_wdt, opt_we, opt_swdt_n, opt_bo_n;
  logic clrwdt, sleep_cmd, wake_pin;
  logic [1:0] fuse_osc;
  logic core_rst, to_flag, pd_flag, wdt_event;
  int checks = 0, errors = 0, ev_cnt = 0;
  bit done = 0;

  rst_guard #(.FILT_LEN(FL), .DRT_SHORT(DS), .DRT_LONG(DL), .WDT_LIMIT(WL)) u0 (
    .clk(clk), .por_n(por_n), .mclr_n(mclr_n), .bod_low(bod_low), .slow_tick(slow_tick),
    .fuse_wdt(fuse_wdt), .fuse_osc(fuse_osc), .opt_we(opt_we), .opt_swdt_n(opt_swdt_n),
    .opt_bo_n(opt_bo_n), .clrwdt(clrwdt), .sleep_cmd(sleep_cmd), .wake_pin(wake_pin),
    .core_rst(core_rst), .to_flag(to_flag), .pd_flag(pd_flag), .wdt_event(wdt_event));

  always @(negedge clk) if (wdt_event === 1'b1) ev_cnt++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      slow_tick = 1'b1; @(negedge clk);
      slow_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wr_opt(input logic s, input logic b);
    opt_swdt_n = s; opt_bo_n = b; opt_we = 1'b1; cyc(1);
    opt_we = 1'b0; cyc(1);
  endtask

  task automatic pulse_clr();   clrwdt = 1'b1;    cyc(1); clrwdt = 1'b0;    cyc(1); endtask
  task automatic pulse_sleep(); sleep_cmd = 1'b1; cyc(1); sleep_cmd = 1'b0; cyc(1); endtask
  task automatic pulse_wake();  wake_pin = 1'b1;  cyc(1); wake_pin = 1'b0;  cyc(1); endtask

  task automatic mclr_pulse(input int w);
    mclr_n = 1'b0; cyc(w); mclr_n = 1'b1; cyc(FL + 6);
  endtask

  task automatic drt(input int len, input string tag);
    tick(len - 1);
    check({tag, " still held"}, int'(core_rst), 1);
    tick(1);
    check({tag, " released"}, int'(core_rst), 0);
  endtask

  function automatic int dlen(input logic [1:0] o);
    return (o == 2'b11) ? DS : DL;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    por_n = 1'b0; mclr_n = 1'b1; bod_low = 1'b0; slow_tick = 1'b0; fuse_wdt = 1'b0;
    fuse_osc = 2'b11; opt_we = 1'b0; opt_swdt_n = 1'b1; opt_bo_n = 1'b1;
    clrwdt = 1'b0; sleep_cmd = 1'b0; wake_pin = 1'b0;
    cyc(3);
    check("R1 reset core_rst", int'(core_rst), 1);
    check("R1 reset to_flag", int'(to_flag), 1);
    check("R1 reset pd_flag", int'(pd_flag), 1);
    check("R1 reset wdt_event", int'(wdt_event), 0);
    por_n = 1'b1; cyc(2);
    drt(DS, "R3 power-on rc");

    bod_low = 1'b1; cyc(4);
    check("R1 brown-out disarmed after power-up", int'(core_rst), 0);
    bod_low = 1'b0;
    tick(WL + 4); cyc(1);
    check("R1 R5 software watchdog off after power-up", ev_cnt, 0);

    for (int w = 1; w < FL; w++) begin
      mclr_pulse(w);
      check("R2 short master clear ignored", int'(core_rst), 0);
    end

    for (int o = 0; o < 4; o++) begin
      fuse_osc = 2'(o);
      mclr_pulse(FL);
      check("R2 full-width master clear accepted", int'(core_rst), 1);
      drt(dlen(fuse_osc), "R3 master clear start-up");
      check("R11 master clear keeps to_flag", int'(to_flag), 1);
      check("R11 master clear keeps pd_flag", int'(pd_flag), 1);
    end
    fuse_osc = 2'b11;

    wr_opt(1'b1, 1'b0);
    bod_low = 1'b1; cyc(2);
    check("R4 armed brown-out resets", int'(core_rst), 1);
    tick(DL + 10);
    check("R4 brown-out holds reset", int'(core_rst), 1);
    bod_low = 1'b0; cyc(1);
    drt(DS, "R3 R4 after brown-out");
    check("R11 brown-out keeps to_flag", int'(to_flag), 1);
    wr_opt(1'b1, 1'b1);
    bod_low = 1'b1; cyc(4);
    check("R4 disarmed brown-out ignored", int'(core_rst), 0);
    bod_low = 1'b0;

    fuse_wdt = 1'b1; cyc(1);
    tick(WL - 1); cyc(1);
    check("R6 no time-out before limit", ev_cnt, 0);
    tick(1); cyc(1);
    check("R6 time-out at limit", ev_cnt, 1);
    check("R6 time-out resets core", int'(core_rst), 1);
    check("R6 time-out clears to_flag", int'(to_flag), 0);
    check("R6 time-out keeps pd_flag", int'(pd_flag), 1);
    pulse_clr();
    check("R10 clrwdt ignored during reset", int'(to_flag), 0);
    fuse_wdt = 1'b0;
    drt(DS, "R3 after time-out");
    pulse_clr();
    check("R7 clrwdt sets to_flag", int'(to_flag), 1);
    check("R7 clrwdt sets pd_flag", int'(pd_flag), 1);

    wr_opt(1'b0, 1'b1);
    tick(WL - 2);
    pulse_clr();
    tick(WL - 1); cyc(1);
    check("R7 clrwdt restarted the count", ev_cnt, 1);
    tick(1); cyc(1);
    check("R5 software enable times out", ev_cnt, 2);
    drt(DS, "R3 after software time-out");
    wr_opt(1'b1, 1'b1);

    fuse_wdt = 1'b1; cyc(1);
    pulse_sleep();
    check("R8 sleep sets to_flag", int'(to_flag), 1);
    check("R8 sleep clears pd_flag", int'(pd_flag), 0);
    fuse_wdt = 1'b0;
    tick(WL - 1); cyc(1);
    check("R8 no early wake", ev_cnt, 2);
    tick(1); cyc(1);
    check("R5 fuse held through sleep", ev_cnt, 3);
    check("R6 sleep time-out to_flag", int'(to_flag), 0);
    check("R6 sleep time-out pd_flag", int'(pd_flag), 0);
    drt(DS, "R3 after sleep time-out");

    pulse_sleep();
    fuse_wdt = 1'b1;
    tick(WL + 4); cyc(1);
    check("R5 fuse set during sleep not seen", ev_cnt, 3);
    pulse_wake();
    check("R9 wake while asleep resets", int'(core_rst), 1);
    check("R9 wake keeps to_flag", int'(to_flag), 1);
    check("R9 wake keeps pd_flag", int'(pd_flag), 0);
    fuse_wdt = 1'b0;
    drt(DS, "R3 after wake");
    pulse_wake();
    check("R9 wake while awake ignored", int'(core_rst), 0);

    pulse_clr();
    pulse_sleep();
    mclr_pulse(FL);
    check("R11 master clear from sleep keeps pd_flag", int'(pd_flag), 0);
    check("R11 master clear from sleep keeps to_flag", int'(to_flag), 1);
    drt(DS, "R3 master clear from sleep");

    done = 1;
    finish_run();
  end
endmodule